// File: doc/BRIEF.md
# TDM time-slot routing sequencer

This block splits a serial time-division-multiplexed frame into consecutive slices. It does this by walking a small table of routing entries, starting at a frame sync pulse. Each entry gives the length of its slice, in bits or in bytes. It also names the serial channel that owns those bits and the strobe lines that are raised while the slice lasts. During a slice, the owning channel's enable is high. The receive line is passed to that channel. On the transmit side, the owning channel's bit is placed on the outgoing line.

There are two independent tables, one for receive and one for transmit, and each has its own sequencer. In common mode, the receive sync drives both sequencers, and every table write lands in both tables, so the two directions stay identical. Tables follow a static-routing discipline: a write is accepted only while every attached serial channel reports itself disabled. A refused write raises a sticky error flag.

Top module: `tdm_slot_router`

## Requirements
- R1: An entry is 15 bits: bit 0 last flag, bit 1 byte unit, bits 4:2 count, bits 8:5 channel code, bits 12:9 strobe pattern, bits 14:13 reserved.
- R2: A slice lasts count+1 serial clocks when the byte unit bit is 0, and (count+1)*8 clocks when it is 1. Its enables and strobes stay constant for the whole slice.
- R3: Channel code 0001 raises enable bit 0, 0010 raises bit 1, 0101 raises bit 2, and every other code raises none. `ch_rx_data_o` equals `rx_data_i` on enabled bits and is 0 elsewhere.
- R4: Strobe pattern bit 12 drives `strobe_o[0]`, bit 11 drives `strobe_o[1]`, bit 10 drives `strobe_o[2]` and bit 9 drives `strobe_o[3]`. Strobes may be raised with or without a channel.
- R5: When sync is sampled high on a clock edge while the sequencer is idle, entry 0 takes effect in the cycle that follows that edge.
- R6: After reset, and after a frame's final slice, all enables and strobes are 0 until the next sync. A sync sampled on the edge that ends the final slice starts the next frame at once, without an error.
- R7: A sync sampled at any other point of a running frame restarts at entry 0 and pulses `frame_err_o` for one cycle, during the first cycle of the restarted frame.
- R8: If no entry carries the last flag, the frame ends after table location DEPTH-1.
- R9: A write while any `chan_en_i` bit is high is discarded and the table is unchanged. Such a write sets `wr_err_o`, which stays set until reset.
- R10: With `common_i` high, each accepted write goes to both tables and `rx_sync_i` starts both sequencers. With it low, `wr_dir_i` (0 receive, 1 transmit) selects the table, and `tx_sync_i` starts the transmit sequencer.
- R11: `tx_data_o` is the `ch_tx_data_i` bit of the channel that the transmit sequencer enables, and 0 when no channel is enabled.
- R12: The reserved bits 14:13 have no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| common_i | input | 1 | Common-clock mode, shares sync and table writes between directions |
| rx_sync_i | input | 1 | Receive frame sync pulse |
| tx_sync_i | input | 1 | Transmit frame sync pulse (used when not in common mode) |
| rx_data_i | input | 1 | Serial receive line |
| tx_data_o | output | 1 | Serial transmit line |
| ch_rx_data_o | output | 3 | Per-channel receive data |
| ch_rx_en_o | output | 3 | Per-channel receive enable |
| ch_tx_data_i | input | 3 | Per-channel transmit data |
| ch_tx_en_o | output | 3 | Per-channel transmit enable |
| strobe_o | output | 4 | Strobe lines, OR of both directions |
| frame_err_o | output | 1 | One-cycle pulse on an early sync |
| chan_en_i | input | 3 | Attached channel enabled flags, which lock the tables |
| wr_en_i | input | 1 | Table write strobe |
| wr_dir_i | input | 1 | Table select, 0 receive, 1 transmit |
| wr_addr_i | input | AW | Entry address, AW = clog2(DEPTH) |
| wr_data_i | input | 15 | Entry value |
| wr_err_o | output | 1 | Sticky refused-write flag |

## Verification
The bench builds the block with DEPTH set to 8. At that size, a table with no last flag ends after eight one-bit slices, so the end-of-table stop (R8) can be checked within a short frame. It still leaves room for the six-slice mixed frame, a 16-bit byte-mode slice, back-to-back frames, an early sync and a refused write. The transmit path is also run on its own with a separate sync, so that the split between the two directions is visible at the ports.

// File: rtl/tdm_rt_pkg.sv
package tdm_rt_pkg;

    localparam int ENTRY_W   = 15;  // external entry width, bits 14:13 reserved
    localparam int ENTRY_KEEP = 13; // bits actually stored
    localparam int NCH       = 3;
    localparam int NSTB      = 4;
    localparam int LEN_W     = 7;   // up to 64 clocks per slice

    typedef struct packed {
        logic [3:0] stb_pat;    // 12:9
        logic [3:0] chan_code;  // 8:5
        logic [2:0] len_m1;     // 4:2
        logic       byte_unit;  // 1
        logic       last;       // 0
    } slot_entry_t;

    // slice length minus one in serial clocks
    function automatic logic [LEN_W-1:0] slice_len_m1(input slot_entry_t e);
        if (e.byte_unit)
            return {1'b0, e.len_m1, 3'b111};
        return {4'b0000, e.len_m1};
    endfunction

    function automatic logic [NCH-1:0] chan_onehot(input logic [3:0] code);
        case (code)
            4'b0001: return 3'b001;
            4'b0010: return 3'b010;
            4'b0101: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [NSTB-1:0] stb_map(input logic [3:0] pat);
        logic [NSTB-1:0] s;
        for (int k = 0; k < NSTB; k++)
            s[k] = pat[NSTB-1-k];
        return s;
    endfunction

endpackage

// File: rtl/tdm_rt_table.sv
module tdm_rt_table
    import tdm_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  slot_entry_t   wdata,
    input  logic [AW-1:0] raddr,
    output slot_entry_t   rdata
);

    slot_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/tdm_rt_seq.sv
module tdm_rt_seq
    import tdm_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync,
    output logic [AW-1:0]   tab_addr,
    input  slot_entry_t     tab_entry,
    output logic [NCH-1:0]  ch_en_o,
    output logic [NSTB-1:0] stb_o,
    output logic            frame_err_o
);

    localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

    logic             running;
    logic [AW-1:0]    idx;
    logic [LEN_W-1:0] rem;
    logic [3:0]       cur_chan;
    logic [3:0]       cur_stb;
    logic             cur_last;

    logic slice_end, frame_end, load, early;
    logic [AW-1:0] next_idx;

    always_comb begin
        slice_end = running && (rem == '0);
        frame_end = slice_end && (cur_last || idx == LAST_LOC);
        early     = sync && running && !frame_end;
        load      = sync || (slice_end && !frame_end);
        next_idx  = sync ? '0 : idx + 1'b1;
    end

    assign tab_addr = next_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            running     <= 1'b0;
            idx         <= '0;
            rem         <= '0;
            cur_chan    <= '0;
            cur_stb     <= '0;
            cur_last    <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            frame_err_o <= early;
            if (load) begin
                running  <= 1'b1;
                idx      <= next_idx;
                rem      <= slice_len_m1(tab_entry);
                cur_chan <= tab_entry.chan_code;
                cur_stb  <= tab_entry.stb_pat;
                cur_last <= tab_entry.last;
            end else if (slice_end) begin
                running <= 1'b0;
            end else if (running) begin
                rem <= rem - 1'b1;
            end
        end
    end

    assign ch_en_o = running ? chan_onehot(cur_chan) : '0;
    assign stb_o   = running ? stb_map(cur_stb)      : '0;

    p_hold_slice_r2: assert property (@(posedge clk) disable iff (rst)
        (running && rem != '0 && !sync) |=> ($stable(ch_en_o) && $stable(stb_o)));

    p_one_route_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_en_o));

    p_start_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> idx == '0);

    p_restart_flag_r7: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> (running && idx == '0));

    p_stop_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        (running && idx == LAST_LOC && rem == '0 && !sync) |=> !running);

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tdm_rt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               common_i,
    input  logic               rx_sync_i,
    input  logic               tx_sync_i,
    input  logic               rx_data_i,
    output logic               tx_data_o,
    output logic [NCH-1:0]     ch_rx_data_o,
    output logic [NCH-1:0]     ch_rx_en_o,
    input  logic [NCH-1:0]     ch_tx_data_i,
    output logic [NCH-1:0]     ch_tx_en_o,
    output logic [NSTB-1:0]    strobe_o,
    output logic               frame_err_o,
    input  logic [NCH-1:0]     chan_en_i,
    input  logic               wr_en_i,
    input  logic               wr_dir_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [ENTRY_W-1:0] wr_data_i,
    output logic               wr_err_o
);

    logic [NCH-1:0]  dir_en   [2];
    logic [NSTB-1:0] dir_stb  [2];
    logic [1:0]      dir_ferr;
    logic            locked;
    logic            unused_reserved;
    slot_entry_t     wr_entry;

    assign locked          = |chan_en_i;
    assign unused_reserved = ^wr_data_i[ENTRY_W-1:ENTRY_KEEP];
    assign wr_entry        = slot_entry_t'(wr_data_i[ENTRY_KEEP-1:0]);

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic          we;
        logic          sync_sel;
        logic [AW-1:0] raddr;
        slot_entry_t   rentry;

        assign we = wr_en_i && !locked && (common_i || (wr_dir_i == 1'(d)));

        if (d == 0) begin : g_rx_sync
            assign sync_sel = rx_sync_i;
        end else begin : g_tx_sync
            assign sync_sel = common_i ? rx_sync_i : tx_sync_i;
        end

        tdm_rt_table #(.DEPTH(DEPTH), .AW(AW)) u_tab (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .waddr (wr_addr_i),
            .wdata (wr_entry),
            .raddr (raddr),
            .rdata (rentry)
        );

        tdm_rt_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
            .clk         (clk),
            .rst         (rst),
            .sync        (sync_sel),
            .tab_addr    (raddr),
            .tab_entry   (rentry),
            .ch_en_o     (dir_en[d]),
            .stb_o       (dir_stb[d]),
            .frame_err_o (dir_ferr[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            wr_err_o <= 1'b0;
        else if (wr_en_i && locked)
            wr_err_o <= 1'b1;
    end

    assign ch_rx_en_o   = dir_en[0];
    assign ch_tx_en_o   = dir_en[1];
    assign ch_rx_data_o = dir_en[0] & {NCH{rx_data_i}};
    assign tx_data_o    = |(dir_en[1] & ch_tx_data_i);
    assign strobe_o     = dir_stb[0] | dir_stb[1];
    assign frame_err_o  = |dir_ferr;

    p_refuse_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && locked) |=> wr_err_o);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |=> wr_err_o);

    p_tx_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (ch_tx_en_o == '0) |-> !tx_data_o);

    p_common_start_r10: assert property (@(posedge clk) disable iff (rst)
        (common_i && rx_sync_i) |=> (ch_rx_en_o == ch_tx_en_o));

endmodule

// File: tb/tdm_slot_router_bench.sv
module tdm_slot_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int AW         = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic common_i = 1'b0, rx_sync_i = 1'b0, tx_sync_i = 1'b0, rx_data_i;
    logic tx_data_o;
    logic [2:0] ch_rx_data_o, ch_rx_en_o, ch_tx_en_o;
    logic [2:0] ch_tx_data_i = 3'b101;
    logic [3:0] strobe_o;
    logic frame_err_o;
    logic [2:0] chan_en_i = '0;
    logic wr_en_i = 1'b0, wr_dir_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [14:0] wr_data_i = '0;
    logic wr_err_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign rx_data_i = cyc[0] ^ cyc[2];

    tdm_slot_router #(.DEPTH(DEPTH)) u_tdm_slot_router (
        .clk(clk), .rst(rst), .common_i(common_i), .rx_sync_i(rx_sync_i),
        .tx_sync_i(tx_sync_i), .rx_data_i(rx_data_i), .tx_data_o(tx_data_o),
        .ch_rx_data_o(ch_rx_data_o), .ch_rx_en_o(ch_rx_en_o),
        .ch_tx_data_i(ch_tx_data_i), .ch_tx_en_o(ch_tx_en_o),
        .strobe_o(strobe_o), .frame_err_o(frame_err_o), .chan_en_i(chan_en_i),
        .wr_en_i(wr_en_i), .wr_dir_i(wr_dir_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .wr_err_o(wr_err_o)
    );

    // bench-side model of both tables
    logic [14:0] m_tab [2][DEPTH];

    typedef struct {
        int         cyc;
        logic [2:0] rxen;
        logic [2:0] txen;
        logic [3:0] stb;
        logic       ferr;
        string      tag;
    } item_t;

    item_t sq[$];

    function automatic logic [14:0] mk(input logic [3:0] stb, input logic [3:0] code,
                                       input logic [2:0] cnt, input logic byt,
                                       input logic lst, input logic [1:0] rsv);
        return {rsv, stb, code, cnt, byt, lst};   // R1 field layout
    endfunction

    function automatic logic [2:0] route(input logic [3:0] code);
        if (code == 4'b0001) return 3'b001;
        if (code == 4'b0010) return 3'b010;
        if (code == 4'b0101) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] stbs(input logic [3:0] p);
        return {p[0], p[1], p[2], p[3]};          // R4 bit order
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) tick();
    endtask

    task automatic wr(input bit dir, input int addr, input logic [14:0] data);
        wr_en_i   = 1'b1;
        wr_dir_i  = dir;
        wr_addr_i = AW'(addr);
        wr_data_i = data;
        if (chan_en_i == '0) begin
            if (common_i) begin
                m_tab[0][addr] = data;
                m_tab[1][addr] = data;
            end else begin
                m_tab[dir][addr] = data;
            end
        end
        tick();
        wr_en_i = 1'b0;
    endtask

    // dir: 0 receive only, 1 transmit only, 2 both from common table
    task automatic expect_frame(input int dir, input int start, input int limit,
                                input bit ferr0, input string tag, output int n);
        int t;
        t = (dir == 1) ? 1 : 0;
        n = 0;
        for (int idx = 0; idx < DEPTH; idx++) begin
            logic [14:0] e;
            int len;
            e = m_tab[t][idx];
            len = e[1] ? (int'(e[4:2]) + 1) * 8 : int'(e[4:2]) + 1;   // R2
            for (int k = 0; k < len && n < limit; k++) begin
                item_t it;
                it.cyc  = start + n;
                it.rxen = (dir != 1) ? route(e[8:5]) : 3'b000;
                it.txen = (dir != 0) ? route(e[8:5]) : 3'b000;
                it.stb  = stbs(e[12:9]);
                it.ferr = ferr0 && (n == 0);
                it.tag  = tag;
                sq.push_back(it);
                n++;
            end
            if (e[0] || n >= limit) break;
        end
    endtask

    task automatic push_idle(input int start, input int count, input string tag);
        for (int k = 0; k < count; k++) begin
            item_t it;
            it.cyc = start + k; it.rxen = '0; it.txen = '0;
            it.stb = '0; it.ferr = 1'b0; it.tag = tag;
            sq.push_back(it);
        end
    endtask

    // monitor: compares the queue head against the outputs away from the edge
    always @(negedge clk) begin
        while (sq.size() > 0 && sq[0].cyc < cyc) begin
            chk(0, {sq[0].tag, " missed slot"}, cyc, sq[0].cyc);
            void'(sq.pop_front());
        end
        if (sq.size() > 0 && sq[0].cyc == cyc) begin
            item_t it;
            it = sq.pop_front();
            chk(ch_rx_en_o == it.rxen, {it.tag, " R3 rx enable"}, ch_rx_en_o, it.rxen);
            chk(ch_rx_data_o == (it.rxen & {3{rx_data_i}}), {it.tag, " R3 rx data"},
                ch_rx_data_o, it.rxen & {3{rx_data_i}});
            chk(ch_tx_en_o == it.txen, {it.tag, " R10 tx enable"}, ch_tx_en_o, it.txen);
            chk(tx_data_o == |(it.txen & ch_tx_data_i), {it.tag, " R11 tx data"},
                tx_data_o, |(it.txen & ch_tx_data_i));
            chk(strobe_o == it.stb, {it.tag, " R4 strobes"}, strobe_o, it.stb);
            chk(frame_err_o == it.ferr, {it.tag, " R7 frame error"}, frame_err_o, it.ferr);
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int s, n, s2, n2;
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < DEPTH; i++) m_tab[d][i] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // reset state, R6
        chk(ch_rx_en_o == 0 && ch_tx_en_o == 0, "R6 reset enables", {ch_rx_en_o, ch_tx_en_o}, 0);
        chk(strobe_o == 0, "R6 reset strobes", strobe_o, 0);
        chk(wr_err_o == 0 && frame_err_o == 0, "R9 reset flags", {wr_err_o, frame_err_o}, 0);

        // six-slice frame, common mode; entry 2 carries reserved bits (R12)
        common_i = 1'b1;
        wr(0, 0, mk(4'b0000, 4'b0010, 3'd0, 1'b1, 1'b0, 2'b00));
        wr(0, 1, mk(4'b1000, 4'b0001, 3'd0, 1'b0, 1'b0, 2'b00));
        wr(0, 2, mk(4'b0000, 4'b0000, 3'd0, 1'b0, 1'b0, 2'b11));
        wr(0, 3, mk(4'b0100, 4'b0000, 3'd3, 1'b0, 1'b0, 2'b00));
        wr(0, 4, mk(4'b0000, 4'b0101, 3'd3, 1'b0, 1'b0, 2'b00));
        wr(0, 5, mk(4'b1000, 4'b0001, 3'd0, 1'b0, 1'b1, 2'b00));

        // R5 / R2 / R12: single frame, 19 clocks, then idle
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(2, s, 1000, 1'b0, "R5", n);
        chk(n == 19, "R2 frame length", n, 19);
        push_idle(s + n, 3, "R6");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + n + 4);

        // R6: back-to-back frames, sync on the final edge
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(2, s, 1000, 1'b0, "R12", n);
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + n - 1);
        rx_sync_i = 1'b1;
        s2 = s + n;
        expect_frame(2, s2, 1000, 1'b0, "R6", n2);
        push_idle(s2 + n2, 2, "R6");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s2 + n2 + 3);

        // R7: early sync in the fifth clock of the first slice
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(2, s, 5, 1'b0, "R7", n);
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + 4);
        rx_sync_i = 1'b1;
        expect_frame(2, s + 5, 1000, 1'b1, "R7", n2);
        push_idle(s + 5 + n2, 2, "R7");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + 5 + n2 + 3);

        // R9: refused write while a channel is enabled
        chan_en_i = 3'b010;
        wr(0, 0, mk(4'b0001, 4'b0001, 3'd7, 1'b1, 1'b1, 2'b00));
        chk(wr_err_o == 1'b1, "R9 refused write flag", wr_err_o, 1);
        chan_en_i = 3'b000;
        tick();
        chk(wr_err_o == 1'b1, "R9 flag sticky", wr_err_o, 1);
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(2, s, 1000, 1'b0, "R9", n);
        push_idle(s + n, 2, "R9");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + n + 3);

        // R10: separate tables; receive gets one 16-clock byte slice on strobe 4
        common_i = 1'b0;
        wr(0, 0, mk(4'b0001, 4'b0001, 3'd1, 1'b1, 1'b1, 2'b00));
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(0, s, 1000, 1'b0, "R10", n);
        chk(n == 16, "R2 byte slice length", n, 16);
        push_idle(s + n, 2, "R10");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + n + 3);

        // R11: transmit only, own sync, old six-slice table
        ch_tx_data_i = 3'b011;
        s = cyc + 1;
        tx_sync_i = 1'b1;
        expect_frame(1, s, 1000, 1'b0, "R11", n);
        push_idle(s + n, 2, "R11");
        tick();
        tx_sync_i = 1'b0;
        wait_cyc(s + n + 3);

        // R8: no last flag anywhere, frame ends at location DEPTH-1
        for (int i = 0; i < DEPTH; i++) begin
            logic [3:0] code;
            code = (i % 4 == 0) ? 4'b0001 : (i % 4 == 1) ? 4'b0010 :
                   (i % 4 == 2) ? 4'b0101 : 4'b0011;
            wr(0, i, mk(4'(1 << (i % 4)), code, 3'd0, 1'b0, 1'b0, 2'b00));
        end
        s = cyc + 1;
        rx_sync_i = 1'b1;
        expect_frame(0, s, 1000, 1'b0, "R8", n);
        chk(n == DEPTH, "R8 frame length", n, DEPTH);
        push_idle(s + n, 3, "R8");
        tick();
        rx_sync_i = 1'b0;
        wait_cyc(s + n + 4);

        chk(sq.size() == 0, "R6 scoreboard drained", sq.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule